// File: doc/BRIEF.md
# Translation Unit Control and Fault Status Registers

This block is the software-visible control and status register set of an address translation unit. Software reaches it through a simple 32-bit register port with separate write and read strobes. A single control word holds the global enable, the pass-through (bypass) flag, the statistics enable, a statistics-zeroing command and a TLB-flush command with a readable busy flag. The same word also carries three sticky fault flags, each with its own enables for abort, interrupt and exception. Three read-only statistics counters count translation hits, misses and stall cycles.

The translation datapath talks to the block through one-cycle event pulses: hit, miss and stall, plus write violation, invalid table entry and address-cap exceeded. It reads back level outputs for enable, bypass, a TLB-flush request, and abort, interrupt and exception. The TLB answers a flush request with a one-cycle done pulse. The TLB and the table walker are not part of this block.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, the control word, all fault flags and all counters are zero, and every level output is low.
- R2: The control word is at byte offset 0x00. Bit 0 is the enable and drives enable_o. Bit 1 is the statistics enable. Bit 8 is bypass and drives bypass_o. The fault enable bits are 9, 10, 11, 17, 18, 19, 24, 25 and 26. A write stores all of these bits, and a read returns them as written.
- R3: The write-violation, invalid-entry and cap-exceeded flags sit at control bits 12, 20 and 27. Each is set by its event pulse whatever its enables are, and it stays set until software clears it.
- R4: Writing a one to a flag bit clears that flag. Writing a zero to it leaves the flag unchanged. If the event pulse arrives in the same cycle as the clearing write, the flag stays set.
- R5: abort_o is high while any flag is set whose abort enable is set. irq_o and exc_o work the same way with the interrupt and exception enables. The abort enables are bits 11, 19 and 26. The interrupt enables are bits 10, 17 and 25. The exception enables are bits 9, 18 and 24. The three bits in each list belong to write violation, invalid entry and cap exceeded, in that order.
- R6: The hit, miss and stall counters read at offsets 0x08, 0x0C and 0x10. Each counts one per event pulse, but only while the statistics enable is set.
- R7: A counter that reaches all ones stays at all ones when further events arrive.
- R8: Writing a one to control bit 3 zeroes all three counters, and this wins over an event in the same cycle. Bit 3 always reads as zero.
- R9: Writing a one to control bit 2 sets the busy bit (bit 7) and tlb_clear_req_o. Bit 2 always reads as zero. Busy stays set until a cycle with tlb_clear_done_i high, and it reads zero from the next cycle on. A done pulse while idle has no effect.
- R10: Writes to the counter offsets are ignored. Reads from any unmapped offset return zero.
- R11: rdata_o takes the addressed register's value on the clock edge where rd_en_i is high. It holds that value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| hit_i | input | 1 | Translation hit event |
| miss_i | input | 1 | Translation miss event |
| stall_i | input | 1 | Stall cycle event |
| wv_fault_i | input | 1 | Write violation event |
| pt_fault_i | input | 1 | Invalid table entry event |
| cap_fault_i | input | 1 | Address cap exceeded event |
| tlb_clear_done_i | input | 1 | TLB flush finished |
| enable_o | output | 1 | Translation enable |
| bypass_o | output | 1 | Pass-through mode |
| tlb_clear_req_o | output | 1 | TLB flush requested, held until done |
| abort_o | output | 1 | Abort request from enabled flags |
| irq_o | output | 1 | Interrupt from enabled flags |
| exc_o | output | 1 | Exception from enabled flags |

## Verification
The bench aims at the collision cases. An event that arrives in the same cycle as the write that clears its flag must leave the flag set; a design that gives priority to the clear would lose a fault. A statistics clear that coincides with a hit must leave the counter at zero; a wrong design would leave it at one. The bench drives a counter well past all ones and expects it to stick there, so a wrapping counter would read a small value. It also checks that the flush busy bit survives idle cycles, falls only after done, and ignores a done pulse that comes while idle. Finally it checks that writes to the counter offsets and toggles of the enable bits do not disturb state they must not touch.

// File: rtl/mmu_ctrl_pkg.sv
// Package: shared register offsets and control-word bit positions for
// the translation unit control registers. Positions are fixed because
// software decodes the control word.
package mmu_ctrl_pkg;

    localparam int NUM_FAULTS = 3;   // 0 write violation, 1 invalid entry, 2 cap exceeded
    localparam int NUM_STATS  = 3;   // 0 hit, 1 miss, 2 stall

    localparam int OFF_CTRL   = 0;
    localparam int OFF_STAT0  = 8;

    localparam int BIT_ENABLE    = 0;
    localparam int BIT_STATS_EN  = 1;
    localparam int BIT_TLB_CLR   = 2;
    localparam int BIT_STATS_CLR = 3;
    localparam int BIT_BUSY      = 7;
    localparam int BIT_BYPASS    = 8;

    localparam int FLAG_POS  [NUM_FAULTS] = '{12, 20, 27};
    localparam int ABORT_POS [NUM_FAULTS] = '{11, 19, 26};
    localparam int IRQ_POS   [NUM_FAULTS] = '{10, 17, 25};
    localparam int EXC_POS   [NUM_FAULTS] = '{9, 18, 24};

    // Byte offset of statistics counter j.
    function automatic int stat_offset(input int j);
        return OFF_STAT0 + 4 * j;
    endfunction

endpackage

// File: rtl/mmu_stat_counter.sv
// Module: saturating event counter.
// Counts one per cycle with inc_i, stops at all ones, and zero_i has
// priority over inc_i. Assumes a synchronous active-low reset.
module mmu_stat_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         zero_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] MAXV = '1;

    // Counter update: reset, clear, or saturating increment.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_o <= '0;
        end else if (zero_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != MAXV)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/mmu_fault_flag.sv
// Module: one sticky fault flag with its abort, interrupt and exception
// enables. The event sets the flag and wins over a write-one clear in the
// same cycle. Enables are loaded on every control-word write.
module mmu_fault_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic event_i,
    input  logic ctrl_wr_i,
    input  logic clr_bit_i,
    input  logic abort_en_bit_i,
    input  logic irq_en_bit_i,
    input  logic exc_en_bit_i,
    output logic flag_o,
    output logic abort_en_o,
    output logic irq_en_o,
    output logic exc_en_o,
    output logic abort_o,
    output logic irq_o,
    output logic exc_o
);

    // Sticky flag: set by the event, cleared by writing a one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_o <= 1'b0;
        end else if (event_i) begin
            flag_o <= 1'b1;
        end else if (ctrl_wr_i && clr_bit_i) begin
            flag_o <= 1'b0;
        end
    end

    // Enable storage: loaded from the control-word write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            abort_en_o <= 1'b0;
            irq_en_o   <= 1'b0;
            exc_en_o   <= 1'b0;
        end else if (ctrl_wr_i) begin
            abort_en_o <= abort_en_bit_i;
            irq_en_o   <= irq_en_bit_i;
            exc_en_o   <= exc_en_bit_i;
        end
    end

    // Per-fault contributions to the shared fault outputs.
    always_comb begin
        abort_o = flag_o & abort_en_o;
        irq_o   = flag_o & irq_en_o;
        exc_o   = flag_o & exc_en_o;
    end

endmodule

// File: rtl/mmu_tlb_clear_seq.sv
// Module: TLB flush command tracker. A start sets busy, and busy falls
// at the edge where done is seen. A start while busy or a done while
// idle has no effect.
module mmu_tlb_clear_seq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o
);

    // Busy state update.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_o <= 1'b0;
        end else if (busy_o && done_i) begin
            busy_o <= 1'b0;
        end else if (start_i) begin
            busy_o <= 1'b1;
        end
    end

endmodule

// File: rtl/mmu_ctrl_regs.sv
// Module: control and fault-status register file for a translation unit.
// Decodes a simple 32-bit register port, holds the control word, three
// sticky faults and three statistics counters, and drives level outputs
// to the datapath. Assumes CNT_W <= 32 and a synchronous active-low reset.
module mmu_ctrl_regs
    import mmu_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              hit_i,
    input  logic              miss_i,
    input  logic              stall_i,
    input  logic              wv_fault_i,
    input  logic              pt_fault_i,
    input  logic              cap_fault_i,
    input  logic              tlb_clear_done_i,
    output logic              enable_o,
    output logic              bypass_o,
    output logic              tlb_clear_req_o,
    output logic              abort_o,
    output logic              irq_o,
    output logic              exc_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFF_CTRL);

    logic                                ctrl_wr;
    logic                                en_q, stats_en_q, bypass_q;
    logic                                stats_clr, tlb_start, tlb_busy;
    logic [NUM_FAULTS-1:0]               fault_ev, flag, flag_clr;
    logic [NUM_FAULTS-1:0]               ab_en, irq_en, exc_en;
    logic [NUM_FAULTS-1:0]               ab_part, irq_part, exc_part;
    logic [NUM_STATS-1:0]                stat_ev, stat_inc;
    logic [NUM_STATS-1:0][CNT_W-1:0]     cnt;
    logic [31:0]                         ctrl_word, rd_next;

    // Write decode for the control word and its command bits.
    always_comb begin
        ctrl_wr   = wr_en_i && (addr_i == CTRL_ADDR);
        stats_clr = ctrl_wr && wdata_i[BIT_STATS_CLR];
        tlb_start = ctrl_wr && wdata_i[BIT_TLB_CLR];
        fault_ev  = {cap_fault_i, pt_fault_i, wv_fault_i};
        stat_ev   = {stall_i, miss_i, hit_i};
        stat_inc  = stat_ev & {NUM_STATS{stats_en_q}};
    end

    // Plain control fields: enable, statistics enable, bypass.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q       <= 1'b0;
            stats_en_q <= 1'b0;
            bypass_q   <= 1'b0;
        end else if (ctrl_wr) begin
            en_q       <= wdata_i[BIT_ENABLE];
            stats_en_q <= wdata_i[BIT_STATS_EN];
            bypass_q   <= wdata_i[BIT_BYPASS];
        end
    end

    // One sticky flag plus enables per fault type.
    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_fault
        assign flag_clr[i] = ctrl_wr && wdata_i[FLAG_POS[i]];
        mmu_fault_flag u_flag (
            .clk_i          (clk_i),
            .rst_ni         (rst_ni),
            .event_i        (fault_ev[i]),
            .ctrl_wr_i      (ctrl_wr),
            .clr_bit_i      (wdata_i[FLAG_POS[i]]),
            .abort_en_bit_i (wdata_i[ABORT_POS[i]]),
            .irq_en_bit_i   (wdata_i[IRQ_POS[i]]),
            .exc_en_bit_i   (wdata_i[EXC_POS[i]]),
            .flag_o         (flag[i]),
            .abort_en_o     (ab_en[i]),
            .irq_en_o       (irq_en[i]),
            .exc_en_o       (exc_en[i]),
            .abort_o        (ab_part[i]),
            .irq_o          (irq_part[i]),
            .exc_o          (exc_part[i])
        );
    end

    // One saturating counter per statistics event.
    for (genvar j = 0; j < NUM_STATS; j++) begin : g_stat
        mmu_stat_counter #(.W(CNT_W)) u_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .inc_i  (stat_inc[j]),
            .zero_i (stats_clr),
            .cnt_o  (cnt[j])
        );
    end

    // TLB flush command and busy tracking.
    mmu_tlb_clear_seq u_tlb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tlb_start),
        .done_i  (tlb_clear_done_i),
        .busy_o  (tlb_busy)
    );

    // Control word assembly for read-back; command bits read as zero.
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[BIT_ENABLE]    = en_q;
        ctrl_word[BIT_STATS_EN]  = stats_en_q;
        ctrl_word[BIT_BUSY]      = tlb_busy;
        ctrl_word[BIT_BYPASS]    = bypass_q;
        for (int i = 0; i < NUM_FAULTS; i++) begin
            ctrl_word[FLAG_POS[i]]  = flag[i];
            ctrl_word[ABORT_POS[i]] = ab_en[i];
            ctrl_word[IRQ_POS[i]]   = irq_en[i];
            ctrl_word[EXC_POS[i]]   = exc_en[i];
        end
    end

    // Read address decode; unmapped offsets give zero.
    always_comb begin
        rd_next = '0;
        if (addr_i == CTRL_ADDR) begin
            rd_next = ctrl_word;
        end
        for (int j = 0; j < NUM_STATS; j++) begin
            if (addr_i == ADDR_W'(stat_offset(j))) begin
                rd_next[CNT_W-1:0] = cnt[j];
            end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_next;
        end
    end

    // Level outputs to the datapath.
    always_comb begin
        enable_o        = en_q;
        bypass_o        = bypass_q;
        tlb_clear_req_o = tlb_busy;
        abort_o         = |ab_part;
        irq_o           = |irq_part;
        exc_o           = |exc_part;
    end

endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
// Module: property checker for mmu_ctrl_regs, bound into every instance.
// Watches flags, counters and flush busy against their controls.
module mmu_ctrl_regs_chk #(
    parameter int NF    = 3,
    parameter int NS    = 3,
    parameter int CNT_W = 32
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [NF-1:0]             flag_i,
    input logic [NF-1:0]             event_i,
    input logic [NF-1:0]             clr_i,
    input logic                      busy_i,
    input logic                      done_i,
    input logic                      start_i,
    input logic [NS-1:0][CNT_W-1:0]  cnt_i,
    input logic [NS-1:0]             inc_i,
    input logic                      zero_i
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    for (genvar i = 0; i < NF; i++) begin : g_f
        // R3: an event sets the flag, even against a same-cycle clear (R4)
        p_event_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            event_i[i] |=> flag_i[i]);
        // R3: a set flag stays set unless written with a one
        p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_i[i] && !clr_i[i]) |=> flag_i[i]);
    end

    for (genvar j = 0; j < NS; j++) begin : g_s
        // R7: a full counter never wraps
        p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cnt_i[j] == MAXV && !zero_i) |=> (cnt_i[j] == MAXV));
        // R6: without an enabled event or clear the counter holds
        p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!inc_i[j] && !zero_i) |=> $stable(cnt_i[j]));
        // R8: statistics clear zeroes the counter
        p_cnt_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            zero_i |=> (cnt_i[j] == '0));
    end

    // R9: busy falls right after done is seen
    p_busy_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && done_i) |=> !busy_i);
    // R9: a start from idle raises busy
    p_busy_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_i) |=> busy_i);
    // R9: busy holds while no done arrives
    p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !done_i) |=> busy_i);

endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk #(
    .NF    (mmu_ctrl_pkg::NUM_FAULTS),
    .NS    (mmu_ctrl_pkg::NUM_STATS),
    .CNT_W (CNT_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flag_i  (flag),
    .event_i (fault_ev),
    .clr_i   (flag_clr),
    .busy_i  (tlb_busy),
    .done_i  (tlb_clear_done_i),
    .start_i (tlb_start),
    .cnt_i   (cnt),
    .inc_i   (stat_inc),
    .zero_i  (stats_clr)
);

// File: tb/sim_mmu_ctrl_regs.sv
// Bench for mmu_ctrl_regs: a control-word vector walk, then directed
// tests for faults, counters, flush and read behaviour. Counters are
// built 4 bits wide so that saturation is reachable.
module sim_mmu_ctrl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          hit = 1'b0, miss = 1'b0, stall = 1'b0;
    logic          wv = 1'b0, pt = 1'b0, cap = 1'b0, done = 1'b0;
    logic          en_o, byp_o, req_o, ab_o, irq_o, exc_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mmu_ctrl_regs #(.ADDR_W(AW), .CNT_W(CW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .hit_i(hit), .miss_i(miss), .stall_i(stall),
        .wv_fault_i(wv), .pt_fault_i(pt), .cap_fault_i(cap),
        .tlb_clear_done_i(done), .enable_o(en_o), .bypass_o(byp_o),
        .tlb_clear_req_o(req_o), .abort_o(ab_o), .irq_o(irq_o), .exc_o(exc_o)
    );

    typedef struct packed {
        logic [31:0] wr;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'h0000_0001},
        '{32'h0000_0102, 32'h0000_0102},
        '{32'h0A0A_0A0A, 32'h020A_0A02},
        '{32'hFFFF_FFFB, 32'h070E_0F03},
        '{32'h0000_0000, 32'h0000_0000}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        tick();
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse_n(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            hit = (which == 0); miss = (which == 1); stall = (which == 2);
            tick();
            hit = 1'b0; miss = 1'b0; stall = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        reg_rd(8'h00, d); check("R1 ctrl", d, 32'h0);
        reg_rd(8'h08, d); check("R1 hit", d, 32'h0);
        check("R1 outputs", {26'h0, en_o, byp_o, req_o, ab_o, irq_o, exc_o}, 32'h0);

        // R2: control word vector walk
        for (int i = 0; i < NV; i++) begin
            reg_wr(8'h00, VECS[i].wr);
            reg_rd(8'h00, d);
            check("R2 readback", d, VECS[i].rd);
            check("R2 enable_o/bypass_o", {30'h0, en_o, byp_o},
                  {30'h0, VECS[i].rd[0], VECS[i].rd[8]});
        end

        // R3: flag set with no enables, no abort
        wv = 1'b1; tick(); wv = 1'b0;
        reg_rd(8'h00, d); check("R3 wv flag", d, 32'h0000_1000);
        check("R3 no abort", {31'h0, ab_o}, 32'h0);
        // R5: abort enable on write violation (writing 0 to flag keeps it)
        reg_wr(8'h00, 32'h0000_0800);
        reg_rd(8'h00, d); check("R4 zero write keeps flag", d, 32'h0000_1800);
        check("R5 abort", {29'h0, ab_o, irq_o, exc_o}, 32'h4);
        // R4: write one clears
        reg_wr(8'h00, 32'h0000_1800);
        reg_rd(8'h00, d); check("R4 w1c", d, 32'h0000_0800);
        check("R5 abort low", {31'h0, ab_o}, 32'h0);
        // R5: invalid-entry interrupt enable at bit 17
        pt = 1'b1; tick(); pt = 1'b0;
        reg_wr(8'h00, 32'h0002_0000);
        check("R5 irq", {29'h0, ab_o, irq_o, exc_o}, 32'h2);
        reg_rd(8'h00, d); check("R3 pt flag", d, 32'h0012_0000);
        reg_wr(8'h00, 32'h0010_0000);
        reg_rd(8'h00, d); check("R4 pt clear", d, 32'h0);
        // R5: cap exception enable at bit 24
        reg_wr(8'h00, 32'h0100_0000);
        cap = 1'b1; tick(); cap = 1'b0;
        check("R5 exc", {29'h0, ab_o, irq_o, exc_o}, 32'h1);
        // R4: event and clear in the same cycle, flag stays
        cap = 1'b1;
        reg_wr(8'h00, 32'h0900_0000);
        cap = 1'b0;
        reg_rd(8'h00, d); check("R4 set wins", d, 32'h0900_0000);
        reg_wr(8'h00, 32'h0800_0000);
        reg_rd(8'h00, d); check("R4 cap clear", d, 32'h0);

        // R7: saturation
        reg_wr(8'h00, 32'h2);
        pulse_n(0, 20);
        reg_rd(8'h08, d); check("R7 saturate", d, 32'hF);
        // R6: miss counting
        pulse_n(1, 3);
        reg_rd(8'h0C, d); check("R6 miss", d, 32'h3);
        // R6: disabled statistics do not count
        reg_wr(8'h00, 32'h0);
        pulse_n(2, 2);
        reg_rd(8'h10, d); check("R6 stall disabled", d, 32'h0);
        reg_wr(8'h00, 32'h2);
        pulse_n(2, 1);
        reg_rd(8'h10, d); check("R6 stall", d, 32'h1);
        // R8: clear wins over a same-cycle hit
        hit = 1'b1;
        reg_wr(8'h00, 32'hA);
        hit = 1'b0;
        reg_rd(8'h08, d); check("R8 hit zero", d, 32'h0);
        reg_rd(8'h0C, d); check("R8 miss zero", d, 32'h0);
        reg_rd(8'h10, d); check("R8 stall zero", d, 32'h0);
        reg_rd(8'h00, d); check("R8 bit3 reads 0", d, 32'h2);
        pulse_n(0, 1);
        reg_rd(8'h08, d); check("R6 hit after clear", d, 32'h1);

        // R10: counter writes ignored, unmapped reads zero
        reg_wr(8'h08, 32'h7);
        reg_rd(8'h08, d); check("R10 counter read-only", d, 32'h1);
        reg_rd(8'h30, d); check("R10 unmapped", d, 32'h0);

        // R11: rdata holds without rd_en
        reg_rd(8'h08, d);
        pulse_n(0, 2);
        check("R11 hold", rdata, 32'h1);
        reg_rd(8'h08, d); check("R11 fresh read", d, 32'h3);

        // R9: done while idle is ignored
        done = 1'b1; tick(); done = 1'b0;
        reg_rd(8'h00, d); check("R9 idle done", d, 32'h2);
        // R9: flush command
        reg_wr(8'h00, 32'h4);
        reg_rd(8'h00, d); check("R9 busy set", d, 32'h80);
        check("R9 req", {31'h0, req_o}, 32'h1);
        tick(); tick(); tick();
        check("R9 busy held", {31'h0, req_o}, 32'h1);
        done = 1'b1; tick(); done = 1'b0;
        check("R9 req drop", {31'h0, req_o}, 32'h0);
        reg_rd(8'h00, d); check("R9 busy clear", d, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule